// File: doc/BRIEF.md
# DRAM Refresh Address Generator

This block paces DRAM refresh. A programmable interval timer counts system clocks. When a period elapses, the block presents the next refresh row address on its row output and raises a request strobe. The external memory controller runs the refresh cycle while the strobe is high, then returns a one-cycle acknowledge. The acknowledge drops the strobe, or keeps it high if more requests are queued, and advances the row counter.

The block only produces the raw row address. Row and column multiplexing and DRAM cycle timing belong to the memory controller. Periods that elapse before an acknowledge arrives are not lost. A small saturating queue records them, so the controller can serve them back to back.

Top module: `refresh_gen`

## Requirements
- R1: After reset, `req_o` is 0, `pend_o` is 0, `row_o` is 0 and the stored interval is zero, so no request is issued.
- R2: With `en_i` high, writing interval N (N ≥ 1) through `ivl_we_i`/`ivl_i` makes `req_o` rise on the N-th rising clock edge after the write edge. Further periods elapse every N clocks after that.
- R3: Once raised, `req_o` stays high and `row_o` holds its value until the first cycle in which `ack_i` is sampled high.
- R4: Each acknowledge taken while `req_o` is high advances `row_o` by one on the next edge. The row wraps from 2^ROW_W−1 to 0.
- R5: An `ack_i` sampled while `req_o` is low has no effect: `row_o` and `pend_o` keep their values.
- R6: A period that elapses while `req_o` is already high increments `pend_o`. `pend_o` saturates at 3, and any further elapsed period is dropped.
- R7: An acknowledge taken while `pend_o` is nonzero keeps `req_o` high, decrements `pend_o` and advances `row_o`. Queued requests are therefore served back to back.
- R8: When an acknowledge is taken in the same cycle that a period elapses, `req_o` stays high and `pend_o` is unchanged, while `row_o` advances.
- R9: Writing the interval restarts the period count from zero, whatever the timer had reached. The next request comes N edges after that write.
- R10: While `en_i` is low, or the stored interval is zero, no request is issued. Any raised or queued request is cleared on the next edge, giving `req_o` = 0 and `pend_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ivl_i | input | IVL_W | New refresh interval in clocks |
| ivl_we_i | input | 1 | Loads `ivl_i` into the interval register and restarts the timer |
| en_i | input | 1 | Refresh enable |
| ack_i | input | 1 | Refresh done, from the memory controller |
| row_o | output | ROW_W | Row address to refresh |
| req_o | output | 1 | Refresh request strobe |
| pend_o | output | QUE_W | Requests queued behind the one being presented |

## Verification
The block has two functions that can fall in the same cycle: a period can elapse in the very cycle the controller acknowledges, and an interval write can coincide with an acknowledge. The bench first fills the queue to saturation with interval 3. It then times its acknowledges so that one of them lands on an expiry cycle, and checks that the strobe stays up, the queue depth holds and the row still advances. A later vector writes a new interval together with an acknowledge. For that vector the bench checks that the acknowledge is honoured and that the next request is timed from the write.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int unsigned ROW_W_DEF = 8;
  localparam int unsigned IVL_W_DEF = 16;
  localparam int unsigned QUE_W_DEF = 2;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int unsigned IVL_W = refresh_pkg::IVL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             ivl_we_i,
  input  logic             en_i,
  output logic [IVL_W-1:0] ivl_o,
  output logic             active_o,
  output logic             tick_o
);
  logic [IVL_W-1:0] ivl_q, cnt_q;

  assign active_o = en_i && (ivl_q != '0);
  // a write cycle never ticks: the period restarts
  assign tick_o   = active_o && !ivl_we_i && (cnt_q == ivl_q - 1'b1);
  assign ivl_o    = ivl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q <= '0;
      cnt_q <= '0;
    end else if (ivl_we_i) begin
      ivl_q <= ivl_i;
      cnt_q <= '0;
    end else if (!active_o || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_req_tracker.sv
module refresh_req_tracker #(
  parameter int unsigned QUE_W = refresh_pkg::QUE_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [QUE_W-1:0] pend_o,
  output logic             take_o
);
  localparam int unsigned N_W   = QUE_W + 2;
  localparam int unsigned N_MAX = 2 ** QUE_W;  // strobe plus full queue

  logic             req_q;
  logic [QUE_W-1:0] pend_q;
  logic [N_W-1:0]   n_cur, n_nxt;

  assign take_o = ack_i && req_q;
  assign n_cur  = N_W'(req_q) + N_W'(pend_q);

  always_comb begin
    n_nxt = n_cur - N_W'(take_o) + N_W'(tick_i);
    if (n_nxt > N_W'(N_MAX)) n_nxt = N_W'(N_MAX);
    if (!active_i) n_nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      req_q  <= (n_nxt != '0);
      pend_q <= (n_nxt == '0) ? '0 : QUE_W'(n_nxt - 1'b1);
    end
  end

  assign req_o  = req_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int unsigned ROW_W = refresh_pkg::ROW_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (step_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/refresh_gen.sv
module refresh_gen #(
  parameter int unsigned ROW_W = refresh_pkg::ROW_W_DEF,
  parameter int unsigned IVL_W = refresh_pkg::IVL_W_DEF,
  parameter int unsigned QUE_W = refresh_pkg::QUE_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             ivl_we_i,
  input  logic             en_i,
  input  logic             ack_i,
  output logic [ROW_W-1:0] row_o,
  output logic             req_o,
  output logic [QUE_W-1:0] pend_o
);
  logic [IVL_W-1:0] ivl_q;
  logic             active, tick, take;

  refresh_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ivl_i(ivl_i), .ivl_we_i(ivl_we_i),
    .en_i(en_i), .ivl_o(ivl_q), .active_o(active), .tick_o(tick)
  );

  refresh_req_tracker #(.QUE_W(QUE_W)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .tick_i(tick),
    .ack_i(ack_i), .req_o(req_o), .pend_o(pend_o), .take_o(take)
  );

  refresh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(take), .row_o(row_o)
  );
endmodule

// File: rtl/refresh_gen_chk.sv
module refresh_gen_chk #(
  parameter int unsigned ROW_W = refresh_pkg::ROW_W_DEF,
  parameter int unsigned IVL_W = refresh_pkg::IVL_W_DEF,
  parameter int unsigned QUE_W = refresh_pkg::QUE_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             ack_i,
  input logic [IVL_W-1:0] ivl_q,
  input logic [ROW_W-1:0] row_o,
  input logic             req_o,
  input logic [QUE_W-1:0] pend_o
);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i && en_i && (ivl_q != '0) |=> req_o);

  p_row_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> $stable(row_o));

  p_row_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> row_o == ROW_W'($past(row_o) + 1'b1));

  p_idle_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |=> $stable(row_o));

  p_queue_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o != '0 |-> req_o);

  p_off_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_o && pend_o == '0);
endmodule

bind refresh_gen refresh_gen_chk #(.ROW_W(ROW_W), .IVL_W(IVL_W), .QUE_W(QUE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ack_i(ack_i), .ivl_q(ivl_q),
  .row_o(row_o), .req_o(req_o), .pend_o(pend_o)
);

// File: tb/refresh_gen_test.sv
module refresh_gen_test;
  localparam int unsigned ROW_W = 8;
  localparam int unsigned IVL_W = 16;
  localparam int unsigned QUE_W = 2;
  localparam int NV = 37;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IVL_W-1:0] ivl_i = '0;
  logic             ivl_we_i = 1'b0;
  logic             en_i = 1'b0;
  logic             ack_i = 1'b0;
  logic [ROW_W-1:0] row_o;
  logic             req_o;
  logic [QUE_W-1:0] pend_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  refresh_gen #(.ROW_W(ROW_W), .IVL_W(IVL_W), .QUE_W(QUE_W)) uut (.*);

  // {we, ivl[7:0], en, ack, req_id[3:0], exp_req, exp_pend[1:0], exp_row[7:0]}
  function automatic logic [25:0] mk(int we, int ivl, int en, int ack, int rq,
                                     int er, int ep, int ew);
    return {1'(we), 8'(ivl), 1'(en), 1'(ack), 4'(rq), 1'(er), 2'(ep), 8'(ew)};
  endfunction

  localparam logic [25:0] VECS [NV] = '{
    mk(1,3,1,0, 9,0,0,0),                                        // R9 load
    mk(0,0,1,0, 2,0,0,0), mk(0,0,1,0, 2,0,0,0),
    mk(0,0,1,0, 2,1,0,0),                                        // R2 first strobe
    mk(0,0,1,0, 3,1,0,0),                                        // R3 held
    mk(0,0,1,1, 4,0,0,1),                                        // R4 ack
    mk(0,0,1,1, 5,1,0,1),                                        // R5 idle ack
    mk(0,0,1,0, 3,1,0,1), mk(0,0,1,0, 3,1,0,1),
    mk(0,0,1,0, 6,1,1,1), mk(0,0,1,0, 6,1,1,1), mk(0,0,1,0, 6,1,1,1), // R6 queue
    mk(0,0,1,0, 6,1,2,1), mk(0,0,1,0, 6,1,2,1), mk(0,0,1,0, 6,1,2,1),
    mk(0,0,1,0, 6,1,3,1), mk(0,0,1,0, 6,1,3,1), mk(0,0,1,0, 6,1,3,1),
    mk(0,0,1,0, 6,1,3,1),                                        // R6 saturate
    mk(0,0,1,1, 7,1,2,2), mk(0,0,1,1, 7,1,1,3),                  // R7 drain
    mk(0,0,1,1, 8,1,1,4),                                        // R8 ack+expiry
    mk(0,0,1,1, 7,1,0,5), mk(0,0,1,1, 4,0,0,6),
    mk(0,0,1,0, 2,1,0,6),
    mk(0,0,0,0,10,0,0,6),                                        // R10 disable
    mk(0,0,1,0, 2,0,0,6), mk(0,0,1,0, 2,0,0,6), mk(0,0,1,0, 2,1,0,6),
    mk(1,5,1,1, 9,0,0,7),                                        // R9 rewrite+ack
    mk(0,0,1,0, 9,0,0,7), mk(0,0,1,0, 9,0,0,7), mk(0,0,1,0, 9,0,0,7),
    mk(0,0,1,0, 9,0,0,7), mk(0,0,1,0, 9,1,0,7),
    mk(1,0,1,0,10,1,0,7),                                        // R10 zero write
    mk(0,0,1,0,10,0,0,7)
  };

  task automatic check(string tag, logic er, logic [1:0] ep, logic [7:0] ew);
    n_chk++;
    if (req_o !== er || pend_o !== ep || row_o !== ew) begin
      n_bad++;
      $display("FAIL %s: req=%0b pend=%0d row=%0d expected req=%0b pend=%0d row=%0d",
               tag, req_o, pend_o, row_o, er, ep, ew);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0, 2'd0, 8'd0);
    rst_ni = 1'b1;
    en_i   = 1'b1;
    repeat (4) @(posedge clk_i);
    #1 check("R1", 1'b0, 2'd0, 8'd0);  // zero interval after reset: silent

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      ivl_we_i = VECS[i][25];
      ivl_i    = IVL_W'(VECS[i][24:17]);
      en_i     = VECS[i][16];
      ack_i    = VECS[i][15];
      @(posedge clk_i);
      #1 check($sformatf("R%0d vec%0d", VECS[i][14:11], i),
               VECS[i][10], VECS[i][9:8], VECS[i][7:0]);
    end

    // R4 wrap: interval 1, permanent ack, row advances every clock
    @(negedge clk_i);
    rst_ni = 1'b0; ivl_we_i = 1'b0; ack_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1; ivl_we_i = 1'b1; ivl_i = IVL_W'(1); en_i = 1'b1; ack_i = 1'b1;
    @(negedge clk_i);
    ivl_we_i = 1'b0;
    for (int k = 0; k < 300 && row_o != 8'hFF; k++) @(negedge clk_i);
    check("R4 at top", 1'b1, 2'd0, 8'hFF);
    @(negedge clk_i);
    check("R4 wrap", 1'b1, 2'd0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule